// File: doc/BRIEF.md
# Slow-Tick Watchdog Timer with Latched Trip Output

This block is a software-serviced watchdog that counts down on a slow 1 kHz time base. The time base comes from a prescaler that divides the system clock. An 8-bit control register holds an enable flag and a two-bit timeout code. Every write to that register reloads the count. An active-low external input also reloads it on every tick for as long as the input is held low. If the count reaches its end, an active-low trip output is asserted. That output stays asserted until software clears the enable flag. A reload does not release it.

The trip output is meant to drive the pull-down of an open-drain pad. A value of 0 means the pad is pulled low, and a value of 1 means the pad is released. A board can place two instances side by side, each with its own register, reload input and trip pin. The register read path returns the enable flag, the timeout code and a sticky expired flag.

Top module: `slow_wdog_timer`

## Requirements
- R1: After reset, `rd_data` reads 0x00, the timer is disabled, and `trip_n` is 1 (released).
- R2: A read returns the enable flag in bit 7, the expired flag in bit 6, the timeout code in bits 1:0, and zeros in bits 5:2. Bits 6:2 of a write are ignored.
- R3: One tick occurs every `CLK_PER_TICK` clocks. Timeout code d (0 to 3) gives `BASE_TICKS * 2^d` ticks. An enabled timer left alone drives `trip_n` low exactly `BASE_TICKS * 2^d * CLK_PER_TICK` clocks after the write edge, and not one clock earlier.
- R4: Any register write reloads the count from the newly written code and restarts the tick phase, so a rewrite before expiry postpones the trip by a full period measured from the rewrite.
- R5: `reload_n` passes through a two-flop synchroniser. While its synchronised value is low, every tick reloads the count, so holding it low prevents expiry. After release, the trip follows one full period after the last reloading tick.
- R6: Once expired, `trip_n` stays low and bit 6 stays set through further ticks, through writes that keep bit 7 at 1, and through `reload_n` activity.
- R7: A write with bit 7 at 0 clears the expired flag at the write edge, so `trip_n` is 1 in the following cycle. A later enable starts a fresh full period.
- R8: While disabled, the timer never expires, whatever time passes or code is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe, one cycle |
| wr_data | input | 8 | Write data: bit 7 enable, bits 1:0 timeout code |
| rd_data | output | 8 | Read data: enable, expired, zeros, timeout code |
| reload_n | input | 1 | Asynchronous active-low external reload |
| trip_n | output | 1 | Active-low pull-down control for the open-drain trip pin |

## Verification
Every result follows from the write edge E. The trip flag is a register read straight to the port, so with the tick phase restarted at E, the trip shows one cycle after edge E + T·P, where T is the tick count and P is `CLK_PER_TICK`. The bench samples on falling edges and checks the edge just before that point (still released) and that point itself (tripped). A disable write clears the flag at its own edge, so release is checked on the falling edge directly after it. External reload passes through two synchroniser flops and then waits up to one tick phase. For that case the bench checks a window of edges X+10 (still released) and X+14 (tripped) after the release edge X, both worked out from P=4 and T=3.

// File: rtl/swdt_pkg.sv
package swdt_pkg;

  // Timeout length in ticks for a two-bit code: base, 2x, 4x, 8x.
  function automatic int unsigned wd_span(input logic [1:0] code,
                                          input int unsigned base);
    return base << code;
  endfunction

endpackage

// File: rtl/swdt_prescale.sv
module swdt_prescale #(
  parameter int unsigned CLK_PER_TICK = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);

  localparam int unsigned PW   = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam int unsigned LAST = CLK_PER_TICK - 1;

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       phase_q <= '0;
    else if (restart_i)               phase_q <= '0;
    else if (phase_q == PW'(LAST))    phase_q <= '0;
    else                              phase_q <= phase_q + 1'b1;
  end

  assign tick_o = (phase_q == PW'(LAST));

  generate
    if (CLK_PER_TICK > 1) begin : g_tick_gap
      // R3: ticks are isolated single-cycle pulses
      p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/swdt_sync.sv
module swdt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/swdt_core.sv
module swdt_core
  import swdt_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic       wr_enable_i,
  input  logic [1:0] wr_code_i,
  input  logic       tick_i,
  input  logic       ext_low_i,
  output logic       en_o,
  output logic [1:0] code_o,
  output logic       expired_o
);

  localparam int unsigned MAX_SPAN = BASE_TICKS * 8;
  localparam int unsigned CW       = $clog2(MAX_SPAN + 1);

  logic          en_q;
  logic [1:0]    code_q;
  logic          expired_q;
  logic [CW-1:0] cnt_q;

  // Named events for the assertions
  logic [CW-1:0] load_val;
  logic [CW-1:0] wr_load_val;
  logic          run_tick;
  logic          at_end;

  assign load_val    = CW'(wd_span(code_q, BASE_TICKS));
  assign wr_load_val = CW'(wd_span(wr_code_i, BASE_TICKS));
  assign run_tick    = tick_i && en_q && !expired_q;
  assign at_end      = (cnt_q <= CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      code_q    <= 2'd0;
      expired_q <= 1'b0;
      cnt_q     <= '0;
    end else if (wr_en_i) begin
      en_q   <= wr_enable_i;
      code_q <= wr_code_i;
      cnt_q  <= wr_load_val;
      if (!wr_enable_i) expired_q <= 1'b0;
    end else if (run_tick) begin
      if (ext_low_i) begin
        cnt_q <= load_val;
      end else if (at_end) begin
        cnt_q     <= '0;
        expired_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign en_o      = en_q;
  assign code_o    = code_q;
  assign expired_o = expired_q;

  // R8: a disabled timer never holds the expired flag
  p_off_no_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !expired_q);

  // R6: expiry only goes away through a disabling write
  p_trip_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_q && !(wr_en_i && !wr_enable_i)) |=> expired_q);

  // R3: expiry is entered only from the last count on a tick
  p_rise_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired_q) |-> ($past(tick_i) && $past(cnt_q) == CW'(1)));

  // R3: the count never exceeds the longest span
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_SPAN));

  // R4: a write loads the span of the written code
  p_write_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (cnt_q == $past(wr_load_val)));

  // R5: a tick seen with external reload low restores the full span
  p_ext_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_tick && ext_low_i && !wr_en_i) |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/slow_wdog_timer.sv
module slow_wdog_timer #(
  parameter int unsigned CLK_PER_TICK = 50000,
  parameter int unsigned BASE_TICKS   = 250,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       reload_n,
  output logic       trip_n
);

  logic       tick;
  logic       reload_sync;
  logic       en;
  logic [1:0] code;
  logic       expired;
  logic       unused_wr_bits;

  assign unused_wr_bits = ^wr_data[6:2];

  swdt_prescale #(.CLK_PER_TICK(CLK_PER_TICK)) u_prescale (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (wr_en),
    .tick_o    (tick)
  );

  swdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (reload_n),
    .sync_o  (reload_sync)
  );

  swdt_core #(.BASE_TICKS(BASE_TICKS)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wr_enable_i (wr_data[7]),
    .wr_code_i   (wr_data[1:0]),
    .tick_i      (tick),
    .ext_low_i   (!reload_sync),
    .en_o        (en),
    .code_o      (code),
    .expired_o   (expired)
  );

  assign rd_data = {en, expired, 4'b0000, code};
  assign trip_n  = !expired;

  // R7: the trip output is released one cycle after a disabling write
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7]) |=> trip_n);

endmodule

// File: tb/test_slow_wdog_timer.sv
module test_slow_wdog_timer;

  localparam int P = 4;
  localparam int B = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       reload_n = 1'b1;
  wire  [7:0] rd_data;
  wire        trip_n;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  slow_wdog_timer #(.CLK_PER_TICK(P), .BASE_TICKS(B)) i_slow_wdog_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .reload_n (reload_n),
    .trip_n   (trip_n)
  );

  function automatic int clocks_for(input int d);
    int t;
    t = B;
    for (int i = 0; i < d; i++) t = t * 2;
    return t * P;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 trip_n", {7'd0, trip_n}, 8'h01);
  endtask

  task automatic t_readback;
    wr(8'h7E);
    chk("R2 ignored bits", rd_data, 8'h02);
    wr(8'h00);
    chk("R2 cleared", rd_data, 8'h00);
  endtask

  task automatic t_spans;
    for (int d = 0; d < 4; d++) begin
      int n;
      n = clocks_for(d);
      wr(8'h00);
      wr(8'h80 | 8'(d));
      adv(n - 1);
      chk("R3 before expiry", {7'd0, trip_n}, 8'h01);
      adv(1);
      chk("R3 at expiry", {7'd0, trip_n}, 8'h00);
      chk("R2 status after expiry", rd_data, 8'hC0 | 8'(d));
    end
    wr(8'h00);
  endtask

  task automatic t_rewrite;
    wr(8'h80);
    adv(8);
    wr(8'h80);
    adv(11);
    chk("R4 postponed", {7'd0, trip_n}, 8'h01);
    adv(1);
    chk("R4 trip after rewrite", {7'd0, trip_n}, 8'h00);
    wr(8'h00);
  endtask

  task automatic t_ext_reload;
    wr(8'h80);
    reload_n = 1'b0;
    adv(100);
    chk("R5 held off trip_n", {7'd0, trip_n}, 8'h01);
    chk("R5 held off status", rd_data, 8'h80);
    reload_n = 1'b1;
    adv(10);
    chk("R5 window low edge", {7'd0, trip_n}, 8'h01);
    adv(4);
    chk("R5 window high edge", {7'd0, trip_n}, 8'h00);
    wr(8'h00);
  endtask

  task automatic t_latch;
    wr(8'h80);
    adv(12);
    chk("R6 expired", {7'd0, trip_n}, 8'h00);
    wr(8'h83);
    adv(200);
    chk("R6 kept after enabled write", {7'd0, trip_n}, 8'h00);
    chk("R6 status kept", rd_data, 8'hC3);
    reload_n = 1'b0;
    adv(20);
    chk("R6 kept under reload", {7'd0, trip_n}, 8'h00);
    reload_n = 1'b1;
    adv(3);
  endtask

  task automatic t_release;
    wr(8'h00);
    chk("R7 released", {7'd0, trip_n}, 8'h01);
    chk("R7 status cleared", rd_data, 8'h00);
    wr(8'h80);
    adv(11);
    chk("R7 fresh period", {7'd0, trip_n}, 8'h01);
    adv(1);
    chk("R7 fresh expiry", {7'd0, trip_n}, 8'h00);
    wr(8'h00);
  endtask

  task automatic t_disabled;
    wr(8'h03);
    adv(300);
    chk("R8 no trip", {7'd0, trip_n}, 8'h01);
    chk("R8 status", rd_data, 8'h03);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    adv(3);
    rst_n = 1'b1;
    adv(1);
    t_reset();
    t_readback();
    t_spans();
    t_rewrite();
    t_ext_reload();
    t_latch();
    t_release();
    t_disabled();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule